// File: doc/BRIEF.md
# Non-Volatile Commit Sequencer

This block schedules the transfer of three live register bytes, two wiper settings and one configuration byte, into a non-volatile store after a bus write transaction closes. The bus interface pulses `write_done_i` on the STOP that ends a write. The sequencer takes a snapshot of the three live bytes at that edge and raises `busy_o`. It then emits one store-write strobe per byte, always all three, whether or not their contents changed.

When zero-crossing gating is enabled at the moment of capture, the strobes wait for the zero-crossing detector to report completion. The store's write time is modelled by a cycle counter that starts at the first strobe. `busy_o` stays high until that count elapses, and the bus interface uses it to withhold its address acknowledge. A master that polls with address bytes therefore sees the device return once `busy_o` falls. A saturating counter records the number of completed commits so that wear can be monitored.

Top module: `nv_commit_seq`

## Requirements
- R1: After reset, `busy_o` is 0, `st_we_o` is 0 and `commit_count_o` is 0.
- R2: A `write_done_i` pulse sampled while idle makes `busy_o` 1 from the next cycle.
- R3: A commit issues strobes on consecutive clocks with `st_addr_o` equal to 0 (wiper 0), then 1 (wiper 1), then 2 (config), one strobe per clock.
- R4: The data written at each address is the value the matching live input held in the cycle `write_done_i` was sampled. Later changes to the live inputs do not reach the strobes of that commit.
- R5: Every commit writes all three addresses, even when no byte changed since the previous commit.
- R6: When `zc_enable_i` is 1 at capture, no strobe occurs until `zc_done_i` is sampled high. The first strobe appears in the cycle after that sample.
- R7: When `zc_enable_i` is 0 at capture, the first strobe appears in the cycle right after `write_done_i`, and `zc_done_i` has no effect.
- R8: `busy_o` stays 1 for exactly `WRITE_CYCLES` cycles counted from the first strobe cycle, then returns to 0.
- R9: A `write_done_i` pulse while `busy_o` is 1 is ignored. It produces no strobes, no change to the committed data and no extra count.
- R10: `commit_count_o` rises by one in the cycle `busy_o` falls, and it holds at its all-ones value once reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| write_done_i | input | 1 | One-cycle pulse: a write transaction has ended |
| zc_enable_i | input | 1 | Zero-crossing gating enable, captured with the snapshot |
| zc_done_i | input | 1 | Zero-crossing event has completed |
| wiper0_i | input | DATA_W | Live wiper 0 setting |
| wiper1_i | input | DATA_W | Live wiper 1 setting |
| config_i | input | DATA_W | Live configuration byte |
| busy_o | output | 1 | Commit in progress; the bus must not acknowledge its address |
| st_we_o | output | 1 | Store write strobe |
| st_addr_o | output | 2 | Store location for the current strobe |
| st_data_o | output | DATA_W | Data for the current strobe |
| commit_count_o | output | CNT_W | Saturating count of completed commits |

## Verification
The sequencing state is what mostly shows at the ports. A wrong strobe index appears as a skipped, repeated or out-of-order `st_addr_o` within the three cycles after the first strobe. A stale or overwritten snapshot appears as wrong `st_data_o` on those same strobes. A timer that loads or counts wrongly moves the falling edge of `busy_o` away from exactly `WRITE_CYCLES` cycles after the first strobe. A faulty wear counter shows up as a wrong `commit_count_o` in the cycle after `busy_o` falls.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ZC   = 2'd1,
        SEQ_PROG = 2'd2
    } seq_state_e;

    localparam int unsigned NUM_LOCS = 3;

    typedef struct packed {
        seq_state_e  state;
        logic [1:0]  idx;
        logic        zc_en;
    } seq_regs_t;

endpackage

// File: rtl/nvc_snapshot.sv
module nvc_snapshot #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_REGS = 3,
    localparam int unsigned SEL_W   = $clog2(NUM_REGS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         capture_i,
    input  logic [NUM_REGS*DATA_W-1:0]   live_i,
    input  logic [SEL_W-1:0]             sel_i,
    output logic [DATA_W-1:0]            data_o
);

    logic [DATA_W-1:0] snap_d [NUM_REGS];
    logic [DATA_W-1:0] snap_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        always_comb begin
            snap_d[g] = snap_q[g];
            if (capture_i) begin
                snap_d[g] = live_i[g*DATA_W +: DATA_W];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap_q[g] <= '0;
            end else begin
                snap_q[g] <= snap_d[g];
            end
        end
    end

    always_comb begin
        data_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel_i == SEL_W'(i)) begin
                data_o = snap_q[i];
            end
        end
    end

endmodule

// File: rtl/nvc_write_timer.sv
module nvc_write_timer #(
    parameter int unsigned WRITE_CYCLES = 20,
    localparam int unsigned TMR_W       = $clog2(WRITE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);

    localparam logic [TMR_W-1:0] LOAD_VAL = TMR_W'(WRITE_CYCLES - 1);

    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = LOAD_VAL;
        end else if (run_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

    AST_TMR_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == LOAD_VAL) else $error("timer load");  // R8

endmodule

// File: rtl/nvc_wear_counter.sv
module nvc_wear_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && cnt_q != '1) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == '1 |=> cnt_q == '1) else $error("counter wrapped");  // R10
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> cnt_q == $past(cnt_q)) else $error("counter moved");  // R10

endmodule

// File: rtl/nv_commit_seq.sv
module nv_commit_seq
    import nvc_pkg::*;
#(
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned WRITE_CYCLES = 20,
    parameter int unsigned CNT_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              write_done_i,
    input  logic              zc_enable_i,
    input  logic              zc_done_i,
    input  logic [DATA_W-1:0] wiper0_i,
    input  logic [DATA_W-1:0] wiper1_i,
    input  logic [DATA_W-1:0] config_i,
    output logic              busy_o,
    output logic              st_we_o,
    output logic [1:0]        st_addr_o,
    output logic [DATA_W-1:0] st_data_o,
    output logic [CNT_W-1:0]  commit_count_o
);

    localparam logic [1:0] LAST_IDX = 2'(NUM_LOCS - 1);
    localparam logic [1:0] DONE_IDX = 2'(NUM_LOCS);

    seq_regs_t r_d, r_q;
    logic      capture;
    logic      tmr_load;
    logic      tmr_expired;
    logic      commit_end;

    always_comb begin
        r_d        = r_q;
        capture    = 1'b0;
        tmr_load   = 1'b0;
        commit_end = 1'b0;
        unique case (r_q.state)
            SEQ_IDLE: begin
                if (write_done_i) begin
                    capture = 1'b1;
                    r_d.zc_en = zc_enable_i;
                    r_d.idx   = '0;
                    if (zc_enable_i) begin
                        r_d.state = SEQ_ZC;
                    end else begin
                        r_d.state = SEQ_PROG;
                        tmr_load  = 1'b1;
                    end
                end
            end
            SEQ_ZC: begin
                if (zc_done_i) begin
                    r_d.state = SEQ_PROG;
                    tmr_load  = 1'b1;
                end
            end
            SEQ_PROG: begin
                if (r_q.idx != DONE_IDX) begin
                    r_d.idx = r_q.idx + 1'b1;
                end
                if (tmr_expired) begin
                    r_d.state  = SEQ_IDLE;
                    commit_end = 1'b1;
                end
            end
            default: r_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: SEQ_IDLE, idx: '0, zc_en: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    nvc_snapshot #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_LOCS)
    ) u_snapshot (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .live_i    ({config_i, wiper1_i, wiper0_i}),
        .sel_i     (r_q.idx),
        .data_o    (st_data_o)
    );

    nvc_write_timer #(
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .run_i     (r_q.state == SEQ_PROG),
        .expired_o (tmr_expired)
    );

    nvc_wear_counter #(
        .CNT_W (CNT_W)
    ) u_wear (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (commit_end),
        .count_o (commit_count_o)
    );

    assign busy_o    = (r_q.state != SEQ_IDLE);
    assign st_we_o   = (r_q.state == SEQ_PROG) && (r_q.idx != DONE_IDX);
    assign st_addr_o = r_q.idx;

    AST_BUSY_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(write_done_i)) else $error("busy rose");  // R2
    AST_FIRST_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_we_o) |-> st_addr_o == 2'd0) else $error("first addr");  // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we_o && st_addr_o != LAST_IDX) |=> (st_we_o && st_addr_o == $past(st_addr_o) + 2'd1))
        else $error("addr step");  // R5
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_we_o |-> st_addr_o <= LAST_IDX) else $error("addr range");  // R3
    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        st_we_o |-> busy_o) else $error("strobe idle");  // R8
    AST_ZC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SEQ_ZC && !zc_done_i) |=> !st_we_o) else $error("zc gate");  // R6

endmodule

// File: tb/nv_commit_seq_tb.sv
module nv_commit_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int WCYC = 8;
    localparam int CW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic write_done = 1'b0, zc_en = 1'b0, zc_done = 1'b0;
    logic [DW-1:0] w0 = '0, w1 = '0, cfg = '0;
    logic busy, st_we;
    logic [1:0] st_addr;
    logic [DW-1:0] st_data;
    logic [CW-1:0] cnt;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nv_commit_seq #(.DATA_W(DW), .WRITE_CYCLES(WCYC), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .write_done_i(write_done),
        .zc_enable_i(zc_en), .zc_done_i(zc_done),
        .wiper0_i(w0), .wiper1_i(w1), .config_i(cfg),
        .busy_o(busy), .st_we_o(st_we), .st_addr_o(st_addr),
        .st_data_o(st_data), .commit_count_o(cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
        end
    endtask

    // Issue a write_done pulse; returns at the negedge after the sampling edge.
    task automatic pulse_done();
        write_done = 1'b1;
        @(negedge clk);
        write_done = 1'b0;
    endtask

    // Checks the W-cycle program window starting at the current negedge.
    task automatic check_window(input logic [DW-1:0] e0, e1, e2, input bit poke_done);
        logic [DW-1:0] exp_d [3];
        exp_d[0] = e0; exp_d[1] = e1; exp_d[2] = e2;
        for (int i = 0; i < WCYC; i++) begin
            check(busy == 1'b1, "R8", busy, 1);
            check(st_we == (i < 3), "R5", st_we, (i < 3));
            if (i < 3) begin
                check(st_addr == 2'(i), "R3", st_addr, i);
                check(st_data == exp_d[i], "R4", st_data, exp_d[i]);
            end
            if (poke_done && i == 4) begin
                w0 = 8'hEE; w1 = 8'hDD; cfg = 8'hCC;
                write_done = 1'b1;
            end else begin
                write_done = 1'b0;
            end
            @(negedge clk);
        end
        write_done = 1'b0;
        exp_cnt = (exp_cnt == 15) ? 15 : exp_cnt + 1;
        check(busy == 1'b0, "R8", busy, 0);
        check(st_we == 1'b0, "R9", st_we, 0);
        check(int'(cnt) == exp_cnt, "R10", cnt, exp_cnt);
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1", busy, 0);
        check(st_we == 1'b0, "R1", st_we, 0);
        check(cnt == '0, "R1", cnt, 0);
    endtask

    task automatic t_plain_commit();
        w0 = 8'h12; w1 = 8'h34; cfg = 8'h56; zc_en = 1'b0;
        zc_done = 1'b1; // R7: ignored when gating disabled
        pulse_done();
        check(busy == 1'b1, "R2", busy, 1);
        check(st_we == 1'b1, "R7", st_we, 1);
        w0 = 8'hA0; w1 = 8'hA1; cfg = 8'hA2; // R4: late change must not leak
        check_window(8'h12, 8'h34, 8'h56, 1'b0);
        zc_done = 1'b0;
    endtask

    task automatic t_same_data();
        w0 = 8'h12; w1 = 8'h34; cfg = 8'h56;
        pulse_done();
        check_window(8'h12, 8'h34, 8'h56, 1'b0); // R5: unchanged bytes rewritten
    endtask

    task automatic t_zc_gate();
        w0 = 8'h5A; w1 = 8'hA5; cfg = 8'h0F; zc_en = 1'b1;
        pulse_done();
        zc_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(busy == 1'b1, "R6", busy, 1);
            check(st_we == 1'b0, "R6", st_we, 0);
            @(negedge clk);
        end
        zc_done = 1'b1;
        @(negedge clk);
        zc_done = 1'b0;
        check_window(8'h5A, 8'hA5, 8'h0F, 1'b0);
    endtask

    task automatic t_ignore_busy();
        w0 = 8'h01; w1 = 8'h02; cfg = 8'h03; zc_en = 1'b0;
        pulse_done();
        check_window(8'h01, 8'h02, 8'h03, 1'b1); // R9: pulse mid-commit
        for (int i = 0; i < 5; i++) begin
            check(busy == 1'b0, "R9", busy, 0);
            check(st_we == 1'b0, "R9", st_we, 0);
            check(int'(cnt) == exp_cnt, "R9", cnt, exp_cnt);
            @(negedge clk);
        end
    endtask

    task automatic t_saturate();
        while (exp_cnt < 15) begin
            pulse_done();
            check_window(8'hEE, 8'hDD, 8'hCC, 1'b0);
        end
        pulse_done();
        check_window(8'hEE, 8'hDD, 8'hCC, 1'b0); // R10: stays at all ones
        check(cnt == 4'hF, "R10", cnt, 15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_commit();
        t_same_data();
        t_zc_gate();
        t_ignore_busy();
        t_saturate();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule